// File: doc/BRIEF.md
# Keyed Write Register Bank

This block is a window of word-wide control registers for a clock-management peripheral. Every register is plain storage. A write only lands when the most significant byte of the write data holds a fixed unlock key. When the write is accepted, that key byte is removed and only the low 24 bits are stored. A write without the key is dropped. The data stays as it was, and the block raises a one-cycle rejection pulse so the bus side can see it.

The write and read sides have separate address, byte-strobe and enable inputs, so a write and a read can both complete in the same cycle. An access counts as legal only when all four byte strobes are set and the byte address is word aligned. Byte lane 0 carries data bits 7:0, which is little-endian order. An illegal write is ignored and flagged. An illegal read returns zero with an error flag. Read data is registered and appears one clock after the request. A constant output publishes the reference oscillator frequency for downstream clock models.

Top module: `keyed_reg_bank`

## Requirements
- R1: After reset every register reads as zero, and `wr_key_err`, `wr_fmt_err`, `rd_valid`, `rd_err` and `rd_data` are all zero.
- R2: A write with `wr_en`=1, `wr_strb`=4'b1111, `wr_addr[1:0]`=0 and `wr_data[31:24]`=8'h5A stores `wr_data[23:0]` in register `wr_addr>>2`. Bits 31:24 of that register always read back as zero.
- R3: A well-formed write whose `wr_data[31:24]` is any value other than 8'h5A leaves every register unchanged. It drives `wr_key_err` high for exactly the one cycle that follows it.
- R4: A write with `wr_strb` not equal to 4'b1111, or with `wr_addr[1:0]` nonzero, is ignored whatever its key. It drives `wr_fmt_err` high for the following cycle and leaves `wr_key_err` low.
- R5: A read request with `rd_en`=1 drives `rd_valid` high on the next cycle. In that cycle `rd_data` holds the word of register `rd_addr>>2`.
- R6: A read with `rd_strb` not equal to 4'b1111, or with `rd_addr[1:0]` nonzero, returns `rd_data`=0 with `rd_err`=1 on the next cycle.
- R7: A write and a read in the same cycle both complete. If they target the same register, the read returns the value held before that write.
- R8: `osc_hz` is a constant equal to the `OSC_HZ` parameter, which defaults to 19,200,000.
- R9: Reads have no side effects. Repeated reads return the same word. In a cycle with no request, `rd_valid` is low and `rd_data` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W (13) | Write byte address |
| wr_strb | input | 4 | Write byte strobes, lane 0 = bits 7:0 |
| wr_data | input | 32 | Write data, key in bits 31:24 |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W (13) | Read byte address |
| rd_strb | input | 4 | Read byte strobes |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after request |
| rd_err | output | 1 | Read rejected for size or alignment |
| wr_key_err | output | 1 | Pulse: write dropped for a wrong key |
| wr_fmt_err | output | 1 | Pulse: write dropped for size or alignment |
| osc_hz | output | 32 | Reference oscillator frequency in Hz |

## Verification
A bad write decode or a wrong storage index only becomes visible when the affected register is read back, so one cycle after that read request. The bench therefore sweeps every register in a reduced 16-word window and reads all of them after each class of stimulus. A lost key strip shows at once as nonzero upper bits in `rd_data`. A misclassified access shows one cycle after it, on the error pulses. A read/write collision bug shows as the new value appearing in the same-cycle read.

// File: rtl/keyed_bank_pkg.sv
package keyed_bank_pkg;

    // Classification of one bus access on either port
    typedef enum logic [1:0] {
        ACC_IDLE    = 2'd0,
        ACC_OK      = 2'd1,
        ACC_FMT_ERR = 2'd2,
        ACC_KEY_ERR = 2'd3
    } acc_status_e;

    // Registered write-side error pulses
    typedef struct packed {
        logic key_err;
        logic fmt_err;
    } wr_flags_t;

endpackage

// File: rtl/kb_access_check.sv
module kb_access_check #(
    parameter int ADDR_W = 13,
    parameter int STRB_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [STRB_W-1:0] strb,
    output logic              fmt_ok
);
    localparam int OFS_W = $clog2(STRB_W);

    logic full_word;
    logic aligned;

    always_comb begin
        full_word = &strb;
        aligned   = (addr[OFS_W-1:0] == '0);
        fmt_ok    = full_word && aligned;
    end
endmodule

// File: rtl/kb_store.sv
module kb_store #(
    parameter int NUM_REGS = 2048,
    parameter int STORE_W  = 24,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [IDX_W-1:0]   widx,
    input  logic [STORE_W-1:0] wword,
    input  logic [IDX_W-1:0]   ridx,
    output logic [STORE_W-1:0] rword
);
    logic [STORE_W-1:0] regs_d [NUM_REGS];
    logic [STORE_W-1:0] regs_q [NUM_REGS];

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            regs_d[widx] = wword;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{default: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    // Read sees the state before any same-cycle write
    assign rword = regs_q[ridx];
endmodule

// File: rtl/kb_read_port.sv
module kb_read_port #(
    parameter int DATA_W  = 32,
    parameter int STORE_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_en,
    input  logic               fmt_ok,
    input  logic [STORE_W-1:0] word,
    output logic [DATA_W-1:0]  rd_data,
    output logic               rd_valid,
    output logic               rd_err
);
    localparam int PAD_W = DATA_W - STORE_W;

    typedef struct packed {
        logic              valid;
        logic              err;
        logic [DATA_W-1:0] data;
    } rd_state_t;

    rd_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = req_en;
        st_d.err   = req_en && !fmt_ok;
        if (req_en) begin
            st_d.data = fmt_ok ? {{PAD_W{1'b0}}, word} : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data  = st_q.data;
    assign rd_valid = st_q.valid;
    assign rd_err   = st_q.err;
endmodule

// File: rtl/keyed_reg_bank.sv
module keyed_reg_bank
    import keyed_bank_pkg::*;
#(
    parameter int              WINDOW_BYTES = 8192,
    parameter int              DATA_W       = 32,
    parameter int              KEY_W        = 8,
    parameter logic [KEY_W-1:0] KEY         = 8'h5A,
    parameter int unsigned     OSC_HZ       = 19_200_000,
    localparam int             ADDR_W       = $clog2(WINDOW_BYTES),
    localparam int             STRB_W       = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [STRB_W-1:0] wr_strb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [STRB_W-1:0] rd_strb,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_err,
    output logic              wr_key_err,
    output logic              wr_fmt_err,
    output logic [31:0]       osc_hz
);
    localparam int OFS_W    = $clog2(STRB_W);
    localparam int NUM_REGS = WINDOW_BYTES / STRB_W;
    localparam int IDX_W    = ADDR_W - OFS_W;
    localparam int STORE_W  = DATA_W - KEY_W;

    logic               wr_fmt_ok;
    logic               rd_fmt_ok;
    logic               key_match;
    acc_status_e        wr_status;
    logic               store_we;
    logic [STORE_W-1:0] rd_word;
    wr_flags_t          flags_d, flags_q;

    kb_access_check #(.ADDR_W(ADDR_W), .STRB_W(STRB_W)) u_wr_check (
        .addr   (wr_addr),
        .strb   (wr_strb),
        .fmt_ok (wr_fmt_ok)
    );

    kb_access_check #(.ADDR_W(ADDR_W), .STRB_W(STRB_W)) u_rd_check (
        .addr   (rd_addr),
        .strb   (rd_strb),
        .fmt_ok (rd_fmt_ok)
    );

    // Write classification: format is judged before the key
    always_comb begin
        key_match = (wr_data[DATA_W-1 -: KEY_W] == KEY);
        if (!wr_en) begin
            wr_status = ACC_IDLE;
        end else if (!wr_fmt_ok) begin
            wr_status = ACC_FMT_ERR;
        end else if (!key_match) begin
            wr_status = ACC_KEY_ERR;
        end else begin
            wr_status = ACC_OK;
        end
        store_we = (wr_status == ACC_OK);
    end

    kb_store #(.NUM_REGS(NUM_REGS), .STORE_W(STORE_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (store_we),
        .widx  (wr_addr[ADDR_W-1:OFS_W]),
        .wword (wr_data[STORE_W-1:0]),
        .ridx  (rd_addr[ADDR_W-1:OFS_W]),
        .rword (rd_word)
    );

    kb_read_port #(.DATA_W(DATA_W), .STORE_W(STORE_W)) u_read (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_en   (rd_en),
        .fmt_ok   (rd_fmt_ok),
        .word     (rd_word),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .rd_err   (rd_err)
    );

    always_comb begin
        flags_d         = '0;
        flags_d.key_err = (wr_status == ACC_KEY_ERR);
        flags_d.fmt_err = (wr_status == ACC_FMT_ERR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign wr_key_err = flags_q.key_err;
    assign wr_fmt_err = flags_q.fmt_err;
    assign osc_hz     = 32'(OSC_HZ);

    // IDX_W kept for readability of the index slice width
    if (IDX_W < 1) begin : g_bad_window
        initial $error("window too small");
    end
endmodule

// File: rtl/kb_checker.sv
module kb_checker #(
    parameter int              WINDOW_BYTES = 8192,
    parameter int              DATA_W       = 32,
    parameter int              KEY_W        = 8,
    parameter logic [KEY_W-1:0] KEY         = 8'h5A,
    localparam int             ADDR_W       = $clog2(WINDOW_BYTES),
    localparam int             STRB_W       = DATA_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [STRB_W-1:0] wr_strb,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid,
    input logic              rd_err,
    input logic              wr_key_err,
    input logic              wr_fmt_err
);
    localparam int OFS_W = $clog2(STRB_W);

    logic wr_good_form;
    assign wr_good_form = (&wr_strb) && (wr_addr[OFS_W-1:0] == '0);

    assert_key_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_good_form && (wr_data[DATA_W-1 -: KEY_W] != KEY)) |=> wr_key_err);

    assert_key_pulse_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_key_err |-> $past(wr_en));

    assert_fmt_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_good_form) |=> (wr_fmt_err && !wr_key_err));

    assert_one_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_key_err, wr_fmt_err}));

    assert_read_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    assert_no_spurious_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    assert_err_zero_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> (rd_valid && rd_data == '0));

    assert_key_stripped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_data[DATA_W-1 -: KEY_W] == '0));
endmodule

bind keyed_reg_bank kb_checker #(
    .WINDOW_BYTES (WINDOW_BYTES),
    .DATA_W       (DATA_W),
    .KEY_W        (KEY_W),
    .KEY          (KEY)
) u_kb_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_strb    (wr_strb),
    .wr_data    (wr_data),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .rd_err     (rd_err),
    .wr_key_err (wr_key_err),
    .wr_fmt_err (wr_fmt_err)
);

// File: tb/test_keyed_reg_bank.sv
module test_keyed_reg_bank;
    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 64;
    localparam int AW         = $clog2(WIN);
    localparam int NREG       = WIN / 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [3:0]    wr_strb = '0;
    logic [31:0]   wr_data = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [3:0]    rd_strb = '0;
    logic [31:0]   rd_data;
    logic          rd_valid, rd_err, wr_key_err, wr_fmt_err;
    logic [31:0]   osc_hz;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    logic [31:0] model [NREG];

    always #(CLK_PERIOD/2) clk = ~clk;

    keyed_reg_bank #(.WINDOW_BYTES(WIN)) i_keyed_reg_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_strb(wr_strb), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_strb(rd_strb),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_err(rd_err),
        .wr_key_err(wr_key_err), .wr_fmt_err(wr_fmt_err), .osc_hz(osc_hz)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // One write cycle; flags checked after the following edge
    task automatic wr(input int a, input logic [31:0] d, input logic [3:0] s,
                      input logic exp_key, input logic exp_fmt, input string req);
        wr_en = 1'b1; wr_addr = AW'(a); wr_strb = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        chk({req, " key_err"}, 32'(wr_key_err), 32'(exp_key));
        chk({req, " fmt_err"}, 32'(wr_fmt_err), 32'(exp_fmt));
    endtask

    task automatic rd(input int a, input logic [3:0] s, input logic [31:0] exp_d,
                      input logic exp_e, input string req);
        rd_en = 1'b1; rd_addr = AW'(a); rd_strb = s;
        @(negedge clk);
        rd_en = 1'b0;
        chk({req, " rd_valid"}, 32'(rd_valid), 32'd1);
        chk({req, " rd_err"}, 32'(rd_err), 32'(exp_e));
        chk({req, " rd_data"}, rd_data, exp_d);
    endtask

    task automatic read_all(input string req);
        for (int i = 0; i < NREG; i++) rd(i * 4, 4'hF, model[i], 1'b0, req);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NREG; i++) model[i] = '0;
        @(negedge clk);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] d;
        logic [31:0] held;
        @(negedge clk);
        do_reset();

        // R1 reset state
        chk("R1 rd_data", rd_data, 32'd0);
        chk("R1 rd_valid", 32'(rd_valid), 32'd0);
        chk("R1 key_err", 32'(wr_key_err), 32'd0);
        chk("R1 fmt_err", 32'(wr_fmt_err), 32'd0);
        read_all("R1 R5 reset readback");

        // R8 constant frequency
        chk("R8 osc_hz", osc_hz, 32'd19_200_000);

        // R2 sweep every register with keyed writes
        for (int i = 0; i < NREG; i++) begin
            d = {8'h5A, 24'(i * 24'h010203) ^ 24'hA5C3F0};
            wr(i * 4, d, 4'hF, 1'b0, 1'b0, "R2 write");
            model[i] = {8'h00, d[23:0]};
        end
        read_all("R2 R5 readback");

        // R3 every key value on register 3
        for (int k = 0; k < 256; k++) begin
            d = {8'(k), 24'(k * 24'h000101) ^ 24'h3C3C3C};
            wr(12, d, 4'hF, (k != 8'h5A), 1'b0, "R3 key sweep");
            if (k == 8'h5A) model[3] = {8'h00, d[23:0]};
            rd(12, 4'hF, model[3], 1'b0, "R3 key sweep readback");
            chk("R3 pulse one cycle", 32'(wr_key_err), 32'd0);
        end
        read_all("R3 other regs untouched");

        // R4 partial strobes and misaligned addresses
        for (int s = 0; s < 15; s++)
            wr(20, 32'h5A123456, 4'(s), 1'b0, 1'b1, "R4 strobe");
        for (int o = 1; o < 4; o++) begin
            wr(20 + o, 32'h5A654321, 4'hF, 1'b0, 1'b1, "R4 misaligned");
            wr(20 + o, 32'h11654321, 4'hF, 1'b0, 1'b1, "R4 misaligned badkey");
        end
        read_all("R4 readback unchanged");

        // R6 malformed reads
        for (int s = 0; s < 15; s++) rd(8, 4'(s), 32'd0, 1'b1, "R6 strobe");
        for (int o = 1; o < 4; o++) rd(8 + o, 4'hF, 32'd0, 1'b1, "R6 misaligned");

        // R7 same-cycle write and read, same register
        wr_en = 1'b1; wr_addr = AW'(28); wr_strb = 4'hF; wr_data = 32'h5A0BEEF0;
        rd_en = 1'b1; rd_addr = AW'(28); rd_strb = 4'hF;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R7 same reg old value", rd_data, model[7]);
        model[7] = 32'h000BEEF0;
        rd(28, 4'hF, model[7], 1'b0, "R7 same reg new value");

        // R7 different registers
        wr_en = 1'b1; wr_addr = AW'(32); wr_strb = 4'hF; wr_data = 32'h5A00C0DE;
        rd_en = 1'b1; rd_addr = AW'(36); rd_strb = 4'hF;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R7 diff reg read", rd_data, model[9]);
        chk("R7 diff reg valid", 32'(rd_valid), 32'd1);
        model[8] = 32'h0000C0DE;
        rd(32, 4'hF, model[8], 1'b0, "R7 diff reg write landed");

        // R9 repeated reads and idle hold
        rd(4, 4'hF, model[1], 1'b0, "R9 read a");
        rd(4, 4'hF, model[1], 1'b0, "R9 read b");
        held = rd_data;
        @(negedge clk);
        chk("R9 idle valid", 32'(rd_valid), 32'd0);
        chk("R9 idle hold", rd_data, held);
        read_all("R9 no side effect");

        // R1 reset after activity
        do_reset();
        chk("R1 post-run rd_data", rd_data, 32'd0);
        read_all("R1 post-run readback");

        summary();
    end
endmodule